// File: doc/BRIEF.md
# Bus-Cycle Serial Memory Host Sequencer

This block sits on the processor side of a bit-serial memory that is attached like an ordinary bus peripheral. The memory is reached only through chip-enable, output-enable and write-enable strobes plus one data line. Every address bit and every data bit therefore travels as a separate bus cycle. A write cycle drives one bit onto the line. A read cycle samples one bit from it. The sequencer takes a single command and expands it into the exact ordered list of bus cycles. The command is a single-byte read, a multi-byte sequential read or a page write, with a 9-bit address and a byte count.

Every operation opens with a reset pattern, which also arms the memory's write latch. A 16-bit address frame follows. The data phase comes after that. A page write then sends a start pattern and polls the data line until the memory reports that programming has ended. Strobe width and the idle gap between cycles are parameters in clock counts. Chip-enable returns high after every cycle, so each cycle ends on a clean edge. Write data enters through a valid/ready stream. While the sequencer waits for a byte, the bus stays idle with all strobes high. Read bytes leave through a valid/ready stream. A byte that has been assembled is held until the consumer takes it, and no further bus cycles are issued while it waits.

Top module: `serial_mem_seq`

## Requirements
- R1: Every accepted command starts with the reset pattern: a read cycle, a write cycle driving 0, and another read cycle.
- R2: The reset pattern is followed by 16 write cycles. The first seven drive 0 and the remaining nine carry address bits 8 down to 0, most significant first.
- R3: Output-enable and write-enable are never both low. During a write cycle the data line is driven (mem_dq_oe=1) with the cycle's bit from the strobe through the first clock after write-enable rises.
- R4: Chip-enable stays low for exactly STROBE_CLK clocks per cycle and stays high for at least GAP_CLK clocks between cycles.
- R5: cmd_op=0 reads one byte: 8 read cycles assembled most significant bit first and presented on rd_data with rd_valid. While rd_valid=1 and rd_ready=0, rd_data stays stable. cmd_ready=0 and busy=1 while a command runs.
- R6: cmd_op=1 reads cmd_len bytes (1..15) with 8 read cycles each and no new address between bytes. The memory supplies consecutive bytes, wrapping from 0x1FF to 0x000.
- R7: cmd_op=2 takes cmd_len bytes from the write stream, one handshake per byte. Each byte is sent as 8 write cycles, most significant bit first. After that comes the start pattern: a read, a write driving 1, and a read.
- R8: After the start pattern the sequencer issues read cycles until one samples 1. It then pulses done with both error flags low.
- R9: A command is rejected with done and err_param pulsing together, and no bus cycle at all, when any of these holds: cmd_op=3; cmd_op=1 with cmd_len=0; cmd_op=2 with cmd_len=0; cmd_op=2 with cmd_addr[2:0]+cmd_len>8.
- R10: If POLL_MAX consecutive status reads all sample 0, done pulses with err_timeout=1 and the sequencer returns to idle.
- R11: mem_wp is high throughout a page-write command and low during read commands.
- R12: Out of reset all strobes are high, mem_dq_oe=0, busy=0, cmd_ready=1 and done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 single read, 1 sequential read, 2 page write, 3 invalid |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_len | input | LEN_W | Byte count for sequential read or page write |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Sequencer waiting for the next write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer accepts the read byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| err_param | output | 1 | Rejected command, with done |
| err_timeout | output | 1 | Status poll expired, with done |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_wp | output | 1 | Write-permit level to the memory |
| mem_dq_out | output | 1 | Data line value when driven |
| mem_dq_oe | output | 1 | Data line drive enable |
| mem_dq_in | input | 1 | Data line sampled value |

## Verification
The hardest situation to reach is the status poll at its edges. In one case the line turns to 1 on exactly the last permitted read. In the other it never turns, and the poll must expire after exactly POLL_MAX reads. The bench plays the memory's side of the data line from a queue of expected cycles. Each queued status read carries the response the bench chooses, so it can hold the line at 0 for any chosen number of polls. Read back-pressure and write-stream stalls come from periodic gaps in rd_ready and wr_valid, which hold the sequencer mid-command while the bus must stay idle.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [1:0] {
    OP_RD1   = 2'd0,
    OP_RDSEQ = 2'd1,
    OP_PGWR  = 2'd2,
    OP_NONE  = 2'd3
  } sms_op_e;

  typedef enum logic {
    CYC_RD = 1'b0,
    CYC_WR = 1'b1
  } sms_cyc_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/sms_cmd_check.sv
module sms_cmd_check
  import sms_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int LEN_W      = 4,
  parameter int PAGE_BYTES = 8
) (
  input  sms_op_e            op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LEN_W-1:0]   len,
  output logic               ok
);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int SUM_W   = ((LEN_W > PAGE_AW) ? LEN_W : PAGE_AW) + 1;

  // position one past the last byte, measured from the page start
  logic [SUM_W-1:0] end_pos;
  assign end_pos = SUM_W'(addr[PAGE_AW-1:0]) + SUM_W'(len);

  always_comb begin
    case (op)
      OP_RD1:   ok = 1'b1;
      OP_RDSEQ: ok = (len != '0);
      OP_PGWR:  ok = (len != '0) && (end_pos <= SUM_W'(PAGE_BYTES));
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/sms_bus_cycle.sv
module sms_bus_cycle
  import sms_pkg::*;
#(
  parameter int STROBE_CLK = 2,
  parameter int GAP_CLK    = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  sms_cyc_e kind,
  input  logic     wbit,
  output logic     done,
  output logic     rbit,
  output logic     ce_n,
  output logic     oe_n,
  output logic     we_n,
  output logic     dq_out,
  output logic     dq_oe,
  input  logic     dq_in
);
  localparam int MAXC = (STROBE_CLK > GAP_CLK) ? STROBE_CLK : GAP_CLK;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {G_IDLE, G_STB, G_GAP} gen_st_e;

  gen_st_e       st;
  logic [CW-1:0] cnt;
  sms_cyc_e      kind_q;
  logic          bit_q;
  logic          rbit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= G_IDLE;
      cnt    <= '0;
      kind_q <= CYC_RD;
      bit_q  <= 1'b0;
      rbit_q <= 1'b1;
    end else begin
      case (st)
        G_IDLE: if (go) begin
          st     <= G_STB;
          cnt    <= CW'(STROBE_CLK - 1);
          kind_q <= kind;
          bit_q  <= wbit;
        end
        G_STB: if (cnt == '0) begin
          st  <= G_GAP;
          cnt <= CW'(GAP_CLK - 1);
          if (kind_q == CYC_RD) rbit_q <= dq_in;
        end else begin
          cnt <= cnt - 1'b1;
        end
        G_GAP: if (cnt == '0) st <= G_IDLE;
               else cnt <= cnt - 1'b1;
        default: st <= G_IDLE;
      endcase
    end
  end

  assign done   = (st == G_GAP) && (cnt == '0);
  assign rbit   = rbit_q;
  assign ce_n   = (st != G_STB);
  assign oe_n   = !((st == G_STB) && (kind_q == CYC_RD));
  assign we_n   = !((st == G_STB) && (kind_q == CYC_WR));
  assign dq_out = bit_q;
  assign dq_oe  = (kind_q == CYC_WR) && (st != G_IDLE);

  // strobe-length tracking for the checks below
  logic        ce_d;
  logic [31:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d    <= 1'b1;
      low_run <= '0;
    end else begin
      ce_d <= ce_n;
      if (!ce_n) low_run <= ce_d ? 32'd1 : low_run + 32'd1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n)); // R3
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (dq_oe && $stable(dq_out))); // R3
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !ce_d) |-> (low_run == 32'(STROBE_CLK))); // R4
endmodule

// File: rtl/sms_seq_ctrl.sv
module sms_seq_ctrl
  import sms_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int LEN_W    = 4,
  parameter int FRAME_W  = 16,
  parameter int POLL_MAX = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  sms_op_e           cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_ok,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err_param,
  output logic              err_timeout,
  output logic              wp_en,
  output logic              cyc_go,
  output sms_cyc_e          cyc_kind,
  output logic              cyc_bit,
  input  logic              cyc_done,
  input  logic              cyc_rbit
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam int PCW   = $clog2(POLL_MAX + 1);
  localparam logic [IDX_W-1:0] IDX_FRAME_LAST = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] IDX_BYTE_LAST  = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_PAT_LAST   = IDX_W'(2);

  typedef enum logic [3:0] {
    C_IDLE, C_RST, C_ADDR, C_WGET, C_WBIT, C_START, C_POLL, C_RBIT, C_RHOLD
  } ctrl_st_e;

  ctrl_st_e           st;
  sms_op_e            op_q;
  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]   left_q;
  logic [IDX_W-1:0]   idx;
  logic [BYTE_W-1:0]  sh;
  logic [PCW-1:0]     poll_cnt;
  logic               done_q, perr_q, terr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= C_IDLE;
      op_q     <= OP_RD1;
      frame_q  <= '0;
      left_q   <= '0;
      idx      <= '0;
      sh       <= '0;
      poll_cnt <= '0;
      done_q   <= 1'b0;
      perr_q   <= 1'b0;
      terr_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      perr_q <= 1'b0;
      terr_q <= 1'b0;
      case (st)
        C_IDLE: if (cmd_valid) begin
          if (!cmd_ok) begin
            done_q <= 1'b1;
            perr_q <= 1'b1;
          end else begin
            st      <= C_RST;
            op_q    <= cmd_op;
            frame_q <= FRAME_W'(cmd_addr);
            left_q  <= (cmd_op == OP_RD1) ? LEN_W'(1) : cmd_len;
            idx     <= '0;
          end
        end
        C_RST: if (cyc_done) begin
          if (idx == IDX_PAT_LAST) begin
            st  <= C_ADDR;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
        C_ADDR: if (cyc_done) begin
          frame_q <= frame_q << 1;
          if (idx == IDX_FRAME_LAST) begin
            idx <= '0;
            st  <= (op_q == OP_PGWR) ? C_WGET : C_RBIT;
          end else idx <= idx + 1'b1;
        end
        C_WGET: if (wr_valid) begin
          sh <= wr_data;
          st <= C_WBIT;
        end
        C_WBIT: if (cyc_done) begin
          sh <= sh << 1;
          if (idx == IDX_BYTE_LAST) begin
            idx    <= '0;
            left_q <= left_q - 1'b1;
            st     <= (left_q == LEN_W'(1)) ? C_START : C_WGET;
          end else idx <= idx + 1'b1;
        end
        C_START: if (cyc_done) begin
          if (idx == IDX_PAT_LAST) begin
            st       <= C_POLL;
            idx      <= '0;
            poll_cnt <= '0;
          end else idx <= idx + 1'b1;
        end
        C_POLL: if (cyc_done) begin
          if (cyc_rbit) begin
            st     <= C_IDLE;
            done_q <= 1'b1;
          end else if (poll_cnt == PCW'(POLL_MAX - 1)) begin
            st     <= C_IDLE;
            done_q <= 1'b1;
            terr_q <= 1'b1;
          end else poll_cnt <= poll_cnt + 1'b1;
        end
        C_RBIT: if (cyc_done) begin
          sh <= {sh[BYTE_W-2:0], cyc_rbit};
          if (idx == IDX_BYTE_LAST) begin
            idx <= '0;
            st  <= C_RHOLD;
          end else idx <= idx + 1'b1;
        end
        C_RHOLD: if (rd_ready) begin
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) begin
            st     <= C_IDLE;
            done_q <= 1'b1;
          end else st <= C_RBIT;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  always_comb begin
    cyc_go   = 1'b0;
    cyc_kind = CYC_RD;
    cyc_bit  = 1'b0;
    case (st)
      C_RST: begin
        cyc_go = 1'b1;
        if (idx == IDX_W'(1)) cyc_kind = CYC_WR;
      end
      C_ADDR: begin
        cyc_go   = 1'b1;
        cyc_kind = CYC_WR;
        cyc_bit  = frame_q[FRAME_W-1];
      end
      C_WBIT: begin
        cyc_go   = 1'b1;
        cyc_kind = CYC_WR;
        cyc_bit  = sh[BYTE_W-1];
      end
      C_START: begin
        cyc_go = 1'b1;
        if (idx == IDX_W'(1)) begin
          cyc_kind = CYC_WR;
          cyc_bit  = 1'b1;
        end
      end
      C_POLL, C_RBIT: cyc_go = 1'b1;
      default: ;
    endcase
  end

  assign cmd_ready   = (st == C_IDLE);
  assign busy        = (st != C_IDLE);
  assign wr_ready    = (st == C_WGET);
  assign rd_valid    = (st == C_RHOLD);
  assign rd_data     = sh;
  assign done        = done_q;
  assign err_param   = perr_q;
  assign err_timeout = terr_q;
  assign wp_en       = (st != C_IDLE) && (op_q == OP_PGWR);

  AST_RD_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R5
  AST_PARAM_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_param |-> (done && !err_timeout && cmd_ready)); // R9
  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (done && !busy)); // R10
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_POLL) |-> (poll_cnt < PCW'(POLL_MAX))); // R10
  AST_REJECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_ok) |=> !cyc_go); // R9
endmodule

// File: rtl/serial_mem_seq.sv
module serial_mem_seq
  import sms_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int LEN_W      = 4,
  parameter int FRAME_W    = 16,
  parameter int PAGE_BYTES = 8,
  parameter int STROBE_CLK = 2,
  parameter int GAP_CLK    = 2,
  parameter int POLL_MAX   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              err_param,
  output logic              err_timeout,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_wp,
  output logic              mem_dq_out,
  output logic              mem_dq_oe,
  input  logic              mem_dq_in
);
  sms_op_e  op_e;
  logic     cmd_ok;
  logic     cyc_go, cyc_bit, cyc_done, cyc_rbit;
  sms_cyc_e cyc_kind;

  assign op_e = sms_op_e'(cmd_op);

  sms_cmd_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
  ) i_check (
    .op(op_e), .addr(cmd_addr), .len(cmd_len), .ok(cmd_ok)
  );

  sms_seq_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FRAME_W(FRAME_W), .POLL_MAX(POLL_MAX)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(op_e),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ok(cmd_ok),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .err_param(err_param), .err_timeout(err_timeout),
    .wp_en(mem_wp),
    .cyc_go(cyc_go), .cyc_kind(cyc_kind), .cyc_bit(cyc_bit),
    .cyc_done(cyc_done), .cyc_rbit(cyc_rbit)
  );

  sms_bus_cycle #(
    .STROBE_CLK(STROBE_CLK), .GAP_CLK(GAP_CLK)
  ) i_bus (
    .clk(clk), .rst_n(rst_n),
    .go(cyc_go), .kind(cyc_kind), .wbit(cyc_bit),
    .done(cyc_done), .rbit(cyc_rbit),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .dq_out(mem_dq_out), .dq_oe(mem_dq_oe), .dq_in(mem_dq_in)
  );
endmodule

// File: tb/test_serial_mem_seq.sv
`timescale 1ns/1ps
module test_serial_mem_seq;
  localparam int STB  = 2;
  localparam int GAP  = 2;
  localparam int PMAX = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cmd_valid, cmd_ready, wr_valid, wr_ready, rd_valid, rd_ready;
  logic [1:0] cmd_op;
  logic [8:0] cmd_addr;
  logic [3:0] cmd_len;
  logic [7:0] wr_data, rd_data;
  logic       busy, done, err_param, err_timeout;
  logic       mem_ce_n, mem_oe_n, mem_we_n, mem_wp, mem_dq_out, mem_dq_oe, mem_dq_in;

  serial_mem_seq #(.STROBE_CLK(STB), .GAP_CLK(GAP), .POLL_MAX(PMAX)) i_serial_mem_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .err_param(err_param), .err_timeout(err_timeout),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_wp(mem_wp),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int fails  = 0;

  // reference model: expected bus cycles with responses, expected read bytes
  bit         q_kind[$];
  bit         q_bit[$];
  bit         q_resp[$];
  string      q_tag[$];
  logic [7:0] exp_rd[$];
  logic [7:0] wq[$];
  logic [7:0] mem [512];
  bit         cur_wr = 1'b0;
  int         ncyc = 0;
  logic       dq_resp = 1'b1;
  assign mem_dq_in = dq_resp;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic refresh_dq();
    dq_resp = (q_resp.size() > 0) ? q_resp[0] : 1'b1;
  endtask

  task automatic push(input bit kind, input bit b, input bit resp, input string tag);
    q_kind.push_back(kind); q_bit.push_back(b); q_resp.push_back(resp); q_tag.push_back(tag);
    refresh_dq();
  endtask

  // bus monitor, sampled at the falling clock edge
  logic ce_d = 1'b1;
  int   low_n = 0, high_n = 100;
  bit   saw_we = 1'b0, saw_oe = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!mem_oe_n && !mem_we_n) chk(1'b0, "R3", "oe and we both low", 1, 0);
    if (!mem_ce_n) begin
      if (ce_d) begin
        chk(high_n >= GAP, "R4", "gap clocks", high_n, GAP);
        low_n = 0; saw_we = 1'b0; saw_oe = 1'b0;
      end
      low_n++;
      if (!mem_we_n) saw_we = 1'b1;
      if (!mem_oe_n) saw_oe = 1'b1;
    end else if (!ce_d) begin
      ncyc++;
      high_n = 1;
      chk(low_n == STB, "R4", "strobe clocks", low_n, STB);
      if (q_kind.size() == 0) begin
        chk(1'b0, "R9", "unexpected bus cycle", ncyc, 0);
      end else begin
        chk((saw_we == q_kind[0]) && (saw_oe == !q_kind[0]), q_tag[0], "cycle kind (1=write)",
            int'(saw_we), int'(q_kind[0]));
        if (q_kind[0])
          chk(mem_dq_oe && (mem_dq_out == q_bit[0]), q_tag[0], "written bit held",
              int'(mem_dq_out), int'(q_bit[0]));
        chk(mem_wp == cur_wr, "R11", "write permit level", int'(mem_wp), int'(cur_wr));
        void'(q_kind.pop_front()); void'(q_bit.pop_front());
        void'(q_resp.pop_front()); void'(q_tag.pop_front());
      end
    end else begin
      high_n++;
    end
    ce_d = mem_ce_n;
    refresh_dq();
  end

  // stream sides
  bit         wr_pend = 1'b0, wr_stall = 1'b0, rd_stall = 1'b0, rd_hold = 1'b0;
  logic [7:0] rd_hold_d = '0;
  string      rd_tag = "R5";
  int         tick = 0;
  always @(negedge clk) if (rst_n) begin
    tick++;
    if (wr_pend) void'(wq.pop_front());
    wr_valid = (wq.size() > 0) && !(wr_stall && (tick % 3 != 0));
    wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
    wr_pend  = wr_valid && wr_ready;
    rd_ready = !(rd_stall && (tick % 4 != 0));
    if (rd_valid) begin
      if (rd_hold) chk(rd_data == rd_hold_d, "R5", "rd_data stable under stall", rd_data, rd_hold_d);
      if (rd_ready) begin
        if (exp_rd.size() == 0) chk(1'b0, rd_tag, "unexpected read byte", rd_data, 0);
        else begin
          chk(rd_data == exp_rd[0], rd_tag, "read byte", rd_data, exp_rd[0]);
          void'(exp_rd.pop_front());
        end
        rd_hold = 1'b0;
      end else begin
        rd_hold = 1'b1; rd_hold_d = rd_data;
      end
    end else begin
      if (rd_hold) chk(1'b0, "R5", "rd_valid dropped without ready", 0, 1);
      rd_hold = 1'b0;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [8:0] addr, input logic [3:0] len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_len = len;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ep, output bit et);
    forever begin
      @(negedge clk);
      if (done) break;
    end
    ep = err_param; et = err_timeout;
  endtask

  task automatic push_prefix(input logic [8:0] addr);
    push(1'b0, 1'b0, 1'b1, "R1");
    push(1'b1, 1'b0, 1'b1, "R1");
    push(1'b0, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 7; i++) push(1'b1, 1'b0, 1'b1, "R2");
    for (int i = 8; i >= 0; i--) push(1'b1, addr[i], 1'b1, "R2");
  endtask

  task automatic run_read(input logic [1:0] op, input logic [8:0] addr, input int n, input string tag);
    bit ep, et;
    logic [7:0] b;
    cur_wr = 1'b0; rd_tag = tag;
    push_prefix(addr);
    for (int k = 0; k < n; k++) begin
      b = mem[(int'(addr) + k) % 512];
      for (int i = 7; i >= 0; i--) push(1'b0, 1'b0, b[i], tag);
      exp_rd.push_back(b);
    end
    issue(op, addr, 4'(n));
    @(negedge clk);
    chk(busy && !cmd_ready, "R5", "busy while running", int'(busy), 1);
    wait_done(ep, et);
    chk(!ep && !et, tag, "read completion flags", int'({ep, et}), 0);
    chk(q_kind.size() == 0 && exp_rd.size() == 0, tag, "all cycles and bytes consumed",
        q_kind.size() + exp_rd.size(), 0);
  endtask

  task automatic run_write(input logic [8:0] addr, input int n, input int polls, input logic [7:0] seed);
    bit ep, et;
    logic [7:0] b;
    cur_wr = 1'b1;
    push_prefix(addr);
    for (int k = 0; k < n; k++) begin
      b = seed + 8'(k * 29);
      wq.push_back(b);
      for (int i = 7; i >= 0; i--) push(1'b1, b[i], 1'b1, "R7");
    end
    push(1'b0, 1'b0, 1'b1, "R7");
    push(1'b1, 1'b1, 1'b1, "R7");
    push(1'b0, 1'b0, 1'b1, "R7");
    for (int p = 0; p < polls && p < PMAX; p++) push(1'b0, 1'b0, 1'b0, (polls >= PMAX) ? "R10" : "R8");
    if (polls < PMAX) push(1'b0, 1'b0, 1'b1, "R8");
    issue(2'd2, addr, 4'(n));
    wait_done(ep, et);
    if (polls >= PMAX) chk(et && !ep, "R10", "timeout flag", int'(et), 1);
    else               chk(!et && !ep, "R8", "clean completion", int'({ep, et}), 0);
    chk(q_kind.size() == 0 && wq.size() == 0, "R7", "all cycles and bytes consumed",
        q_kind.size() + wq.size(), 0);
    @(negedge clk);
    chk(!busy && !mem_wp, "R11", "idle after write", int'({busy, mem_wp}), 0);
    cur_wr = 1'b0;
  endtask

  task automatic run_reject(input logic [1:0] op, input logic [8:0] addr, input logic [3:0] len);
    bit ep, et;
    int n0;
    n0 = ncyc;
    issue(op, addr, len);
    wait_done(ep, et);
    chk(ep && !et, "R9", "reject flag", int'(ep), 1);
    repeat (8) @(negedge clk);
    chk(ncyc == n0 && mem_ce_n, "R9", "no bus cycle after reject", ncyc - n0, 0);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 5);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = '0; cmd_len = '0;
    wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R12", "strobes idle",
        int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}), 4'b1110);
    chk(!busy && cmd_ready && !done, "R12", "control idle", int'({busy, cmd_ready, done}), 3'b010);

    run_read(2'd0, 9'h1A5, 1, "R5");
    rd_stall = 1'b1;
    run_read(2'd0, 9'h03C, 1, "R5");
    run_read(2'd1, 9'h1FE, 4, "R6");
    rd_stall = 1'b0;
    run_read(2'd1, 9'h100, 9, "R6");

    wr_stall = 1'b1;
    run_write(9'h010, 8, 3, 8'h5A);
    wr_stall = 1'b0;
    run_write(9'h0F5, 3, 0, 8'hC3);
    run_write(9'h1F8, 1, PMAX - 1, 8'h81);

    run_reject(2'd2, 9'h020, 4'd0);
    run_reject(2'd2, 9'h020, 4'd9);
    run_reject(2'd2, 9'h0F6, 4'd3);
    run_reject(2'd1, 9'h000, 4'd0);
    run_reject(2'd3, 9'h000, 4'd1);

    run_write(9'h040, 2, PMAX, 8'h11);
    run_read(2'd0, 9'h1FF, 1, "R5");

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule